// File: doc/BRIEF.md
# Load Data Formatter

This block sits at the tail of a load pipeline. Memory returns a 128-bit raw bus, and the block turns it into the value that is written back to a destination register. For a quadword access it produces two values, one for an even register and one for an odd register. A load is described by five controls: an access size, a sign-extend select, a byte-reverse select, an endian-mode bit and a valid strobe. The result appears one clock later on registered outputs, together with a write enable for each register of the pair.

The raw bus holds memory bytes in address order, starting at the most significant end. Byte k of the access is `data_i[127-8k -: 8]`. Register bits are counted from the most significant end, so register bit 0 is `even_o[63]`. The block does not generate addresses and does not talk to memory.

Top module: `lfmt_top`

## Requirements
- R1: While `rst_ni` is low, all outputs are zero: both values and both write enables.
- R2: The size codes on `size_i` are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes and 4 = 16 bytes. One clock after `valid_i` is high with a legal code, `even_we_o` is high for that one cycle. It is low in every cycle that follows a cycle with no valid load.
- R3: For a 1-byte load, `even_o[7:0]` is memory byte 0 (`data_i[127:120]`) and `even_o[63:8]` is zero. This holds whatever the sign-extend and byte-reverse selects are.
- R4: For a 2-byte or 4-byte load with both selects low, the bytes appear in address order, most significant first, in the low 16 or 32 bits. All higher bits are zero.
- R5: For a 2-byte or 4-byte load with sign extend high and byte reverse low, the bits above the item are copies of the item's most significant bit, which is bit 7 of memory byte 0.
- R6: Sign extend has no effect on 1-byte and 8-byte loads, and none on any load with byte reverse high.
- R7: With byte reverse high, a 2-, 4- or 8-byte load places memory byte 0 in `even_o[7:0]`, memory byte 1 in `even_o[15:8]`, and so on up the register. Bits above the item are zero.
- R8: An 8-byte load with byte reverse low passes `data_i[127:64]` to `even_o` unchanged.
- R9: For a 16-byte load with `le_i` low, `even_o` = `data_i[127:64]` and `odd_o` = `data_i[63:0]`. The sign-extend and byte-reverse selects are ignored.
- R10: For a 16-byte load with `le_i` high, `even_o` is bytes 8..15 with byte 8 in bits 7:0 and byte 15 in bits 63:56. `odd_o` is bytes 0..7 with byte 0 in bits 7:0. Both selects are ignored.
- R11: `odd_we_o` is high only in the cycle after a valid 16-byte load. After any valid narrower load, `odd_o` is zero. `le_i` has no effect on loads narrower than 16 bytes.
- R12: A valid strobe with size code 5, 6 or 7 raises neither write enable, and both value outputs keep their previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Load data present this cycle |
| size_i | input | 3 | Access size code |
| sext_i | input | 1 | Sign-extend select |
| brev_i | input | 1 | Byte-reverse select |
| le_i | input | 1 | Little-endian mode |
| data_i | input | 128 | Raw memory bytes, byte 0 at the top |
| even_o | output | 64 | Value for the even or only destination |
| odd_o | output | 64 | Value for the odd destination |
| even_we_o | output | 1 | Write enable for the even destination |
| odd_we_o | output | 1 | Write enable for the odd destination |

## Verification
The bench builds the block with its default 64-bit register width, which is the only width for which the 2-, 4- and 8-byte lanes and the quadword pair all exist together. Random size codes cover all eight values, including the three illegal ones. Random select bits therefore reach every combination of sign extend, byte reverse and endian mode at every size. Directed patterns put set top bits in byte 0 and in byte 8, so sign fill, zero fill and doubleword swapping each show up as visible differences.

// File: rtl/lfmt_pkg.sv
package lfmt_pkg;
  typedef enum logic [2:0] {
    SZ_B = 3'd0,
    SZ_H = 3'd1,
    SZ_W = 3'd2,
    SZ_D = 3'd3,
    SZ_Q = 3'd4
  } size_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/lfmt_narrow.sv
module lfmt_narrow
  import lfmt_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] item_i,
  input  logic [2:0]      size_i,
  input  logic            sext_i,
  input  logic            brev_i,
  output logic [XLEN-1:0] val_o
);
  localparam int unsigned NBYTE = XLEN / BYTE_W;

  logic [XLEN-1:0] rev_d;
  logic [15:0]     h_sel;
  logic [31:0]     w_sel;
  logic            sx_on;

  // byte g of memory lands in register byte g counted from the LSB
  for (genvar g = 0; g < NBYTE; g++) begin : g_rev
    assign rev_d[g*BYTE_W +: BYTE_W] = item_i[XLEN-1-g*BYTE_W -: BYTE_W];
  end

  assign h_sel = brev_i ? rev_d[15:0] : item_i[XLEN-1 -: 16];
  assign w_sel = brev_i ? rev_d[31:0] : item_i[XLEN-1 -: 32];
  assign sx_on = sext_i & ~brev_i;

  always_comb begin
    unique case (size_i)
      SZ_B:    val_o = {{(XLEN-8){1'b0}}, item_i[XLEN-1 -: 8]};
      SZ_H:    val_o = {{(XLEN-16){h_sel[15] & sx_on}}, h_sel};
      SZ_W:    val_o = {{(XLEN-32){w_sel[31] & sx_on}}, w_sel};
      SZ_D:    val_o = brev_i ? rev_d : item_i;
      default: val_o = '0;
    endcase
  end
endmodule

// File: rtl/lfmt_quad.sv
module lfmt_quad
  import lfmt_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [2*XLEN-1:0] data_i,
  input  logic              le_i,
  output logic [XLEN-1:0]   even_o,
  output logic [XLEN-1:0]   odd_o
);
  localparam int unsigned NBYTE = XLEN / BYTE_W;

  logic [XLEN-1:0] first_dw, second_dw, first_sw, second_sw;

  assign first_dw  = data_i[2*XLEN-1 -: XLEN];
  assign second_dw = data_i[XLEN-1:0];

  for (genvar g = 0; g < NBYTE; g++) begin : g_sw
    assign first_sw[g*BYTE_W +: BYTE_W]  = first_dw[XLEN-1-g*BYTE_W -: BYTE_W];
    assign second_sw[g*BYTE_W +: BYTE_W] = second_dw[XLEN-1-g*BYTE_W -: BYTE_W];
  end

  // little endian: swap halves and reverse bytes within each
  assign even_o = le_i ? second_sw : first_dw;
  assign odd_o  = le_i ? first_sw  : second_dw;
endmodule

// File: rtl/lfmt_top.sv
module lfmt_top
  import lfmt_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        size_i,
  input  logic              sext_i,
  input  logic              brev_i,
  input  logic              le_i,
  input  logic [2*XLEN-1:0] data_i,
  output logic [XLEN-1:0]   even_o,
  output logic [XLEN-1:0]   odd_o,
  output logic              even_we_o,
  output logic              odd_we_o
);
  logic [XLEN-1:0] narrow_val, q_even, q_odd;
  logic [XLEN-1:0] even_d, odd_d;
  logic            is_q, take;

  lfmt_narrow #(.XLEN(XLEN)) u_narrow (
    .item_i (data_i[2*XLEN-1 -: XLEN]),
    .size_i (size_i),
    .sext_i (sext_i),
    .brev_i (brev_i),
    .val_o  (narrow_val)
  );

  lfmt_quad #(.XLEN(XLEN)) u_quad (
    .data_i (data_i),
    .le_i   (le_i),
    .even_o (q_even),
    .odd_o  (q_odd)
  );

  assign is_q   = (size_i == SZ_Q);
  assign take   = valid_i && (size_i <= SZ_Q);
  assign even_d = is_q ? q_even : narrow_val;
  assign odd_d  = is_q ? q_odd : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      even_o    <= '0;
      odd_o     <= '0;
      even_we_o <= 1'b0;
      odd_we_o  <= 1'b0;
    end else begin
      even_we_o <= take;
      odd_we_o  <= take & is_q;
      if (take) begin
        even_o <= even_d;
        odd_o  <= odd_d;
      end
    end
  end
endmodule

// File: rtl/lfmt_chk.sv
module lfmt_chk
  import lfmt_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        size_i,
  input logic              sext_i,
  input logic              brev_i,
  input logic              le_i,
  input logic [2*XLEN-1:0] data_i,
  input logic [XLEN-1:0]   even_o,
  input logic [XLEN-1:0]   odd_o,
  input logic              even_we_o,
  input logic              odd_we_o
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (even_o == '0 && odd_o == '0 && !even_we_o && !odd_we_o));

  a_r2_no_load_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !even_we_o && !odd_we_o);

  a_r3_byte_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == SZ_B) |=> even_o[XLEN-1:8] == '0);

  a_r5_half_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == SZ_H && sext_i && !brev_i)
      |=> even_o[XLEN-1:16] == {(XLEN-16){$past(data_i[2*XLEN-1])}});

  a_r8_dw_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == SZ_D && !brev_i) |=> even_o == $past(data_i[2*XLEN-1 -: XLEN]));

  a_r9_quad_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == SZ_Q && !le_i) |=> odd_o == $past(data_i[XLEN-1:0]) && odd_we_o);

  a_r10_quad_le_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == SZ_Q && le_i) |=> odd_o[7:0] == $past(data_i[2*XLEN-1 -: 8]));

  a_r11_odd_we_narrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i < SZ_Q) |=> !odd_we_o && odd_o == '0 && even_we_o);

  a_r12_bad_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i > SZ_Q) |=> !even_we_o && !odd_we_o && $stable(even_o) && $stable(odd_o));
endmodule

bind lfmt_top lfmt_chk #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .size_i    (size_i),
  .sext_i    (sext_i),
  .brev_i    (brev_i),
  .le_i      (le_i),
  .data_i    (data_i),
  .even_o    (even_o),
  .odd_o     (odd_o),
  .even_we_o (even_we_o),
  .odd_we_o  (odd_we_o)
);

// File: tb/tb_lfmt_top.sv
module tb_lfmt_top;
  localparam int CLK_P = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [2:0]   size_i = '0;
  logic         sext_i = 1'b0, brev_i = 1'b0, le_i = 1'b0;
  logic [127:0] data_i = '0;
  logic [63:0]  even_o, odd_o;
  logic         even_we_o, odd_we_o;

  int checks = 0, errors = 0;
  logic [63:0] exp_even = '0, exp_odd = '0;
  logic        exp_ewe = 1'b0, exp_owe = 1'b0;
  string       tag;

  always #(CLK_P/2) clk_i = ~clk_i;

  lfmt_top dut (.*);

  function automatic logic [7:0] mb(logic [127:0] d, int k);
    return d[127-8*k -: 8];
  endfunction

  task automatic model(logic [127:0] d, logic [2:0] sz, logic sx, logic br, logic le);
    int n;
    logic [63:0] v;
    v = '0;
    exp_ewe = (sz <= 3'd4);
    exp_owe = (sz == 3'd4);
    if (sz > 3'd4) begin
      tag = "R12";
      return;
    end
    if (sz == 3'd4) begin
      tag = le ? "R10" : "R9";
      exp_even = '0;
      exp_odd  = '0;
      for (int k = 0; k < 8; k++) begin
        if (le) begin
          exp_even |= 64'(mb(d, 8+k)) << (8*k);
          exp_odd  |= 64'(mb(d, k)) << (8*k);
        end else begin
          exp_even = (exp_even << 8) | 64'(mb(d, k));
          exp_odd  = (exp_odd << 8) | 64'(mb(d, 8+k));
        end
      end
      return;
    end
    n = 1 << sz;
    for (int k = 0; k < n; k++) begin
      if (br) v |= 64'(mb(d, k)) << (8*k);
      else    v = (v << 8) | 64'(mb(d, k));
    end
    if (sx && !br && (n == 2 || n == 4) && v[8*n-1])
      v |= ~((64'd1 << (8*n)) - 64'd1);
    exp_even = v;
    exp_odd  = '0;
    if (sz == 3'd0)               tag = "R3";
    else if (sx && (br || n == 8)) tag = "R6";
    else if (br)                  tag = "R7";
    else if (n == 8)              tag = "R8";
    else if (sx)                  tag = "R5";
    else                          tag = "R4";
  endtask

  task automatic check(string t);
    checks++;
    if (even_o !== exp_even || odd_o !== exp_odd ||
        even_we_o !== exp_ewe || odd_we_o !== exp_owe) begin
      errors++;
      $display("FAIL %s: act even=%h odd=%h we=%b%b exp even=%h odd=%h we=%b%b",
               t, even_o, odd_o, even_we_o, odd_we_o,
               exp_even, exp_odd, exp_ewe, exp_owe);
    end
  endtask

  task automatic load(logic [127:0] d, logic [2:0] sz, logic sx, logic br, logic le);
    data_i = d; size_i = sz; sext_i = sx; brev_i = br; le_i = le; valid_i = 1'b1;
    model(d, sz, sx, br, le);
    @(negedge clk_i);
    check(tag);
    valid_i = 1'b0;
  endtask

  task automatic idle_check;
    exp_ewe = 1'b0; exp_owe = 1'b0;
    @(negedge clk_i);
    check("R2 idle");
  endtask

  localparam logic [127:0] PAT_A = 128'h8192_A3B4_C5D6_E7F8_F1E2_D3C4_B5A6_9788;
  localparam logic [127:0] PAT_B = 128'h7F01_0203_0405_0607_8899_AABB_CCDD_EEFF;

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: act running exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk_i);
    @(negedge clk_i);
    check("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release");
    for (int s = 0; s < 5; s++)
      for (int f = 0; f < 8; f++) begin
        load(PAT_A, 3'(s), f[0], f[1], f[2]);
        load(PAT_B, 3'(s), f[0], f[1], f[2]);
      end
    load(PAT_A, 3'd4, 1'b0, 1'b0, 1'b0);
    load(PAT_B, 3'd5, 1'b1, 1'b0, 1'b0);
    load(PAT_A, 3'd7, 1'b0, 1'b1, 1'b1);
    idle_check();
    for (int i = 0; i < 3000; i++) begin
      load({$urandom, $urandom, $urandom, $urandom}, 3'($urandom_range(0, 7)),
           1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 9) == 0) idle_check();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule